// File: doc/BRIEF.md
# Multi-Channel Pulse-Per-Second Timestamper

This block records when each of several once-per-second pulses arrives. All channels are measured against one free-running 32-bit counter. Every channel has an input synchronizer and a rising-edge detector. A channel can also be given a divider, which turns a fast frequency input (for example a 10 MHz oscillator) into one pulse per second. When a pulse edge is seen, the channel copies the shared count into its own holding register. An arbiter then moves the held values, one per clock, into a single queue. Each queue entry carries the channel number.

A processor empties the queue by reading the same word again and again. The word shows the oldest record; asserting `rd_en` for one cycle removes that record. Channel 0 is kept undivided and is meant for the pulse from a satellite timing receiver. Software can subtract its timestamps from those of the other channels. If the queue is full, records are lost and a sticky flag is raised. A one-cycle `clr_ovf` strobe clears the flag.

Top module: `pps_stamper`

## Requirements
- R1: The shared counter is 0 while in reset and goes up by one on every clock edge after reset. Clock edges after reset release are numbered from 1. If a pulse input is first sampled high at edge k, its record holds the stamp k+1.
- R2: The read word is 36 bits: bit 35 is valid, bits 34:32 are the channel number, and bits 31:0 are the captured count.
- R3: Records come out in the order they went in. Asserting `rd_en` for one cycle while the queue holds data removes exactly the record being shown.
- R4: If several channels capture in the same cycle, their records go into the queue lowest channel number first, all with the same stamp.
- R5: A channel set in `DIV_MASK` makes a record only on its DIV_N-th, 2·DIV_N-th, … rising edge after reset. That record is stamped as in R1, using the input edge that completed the count. Channel 0 is never divided.
- R6: A record that arrives while the queue is full is dropped, and `ovf_flag` is set. The flag stays set until `clr_ovf` is high at a clock edge. The records already in the queue are kept unchanged.
- R7: While the queue is empty, the read word is all zeros, so its valid bit is 0. Asserting `rd_en` while the queue is empty has no effect.
- R8: Each rising edge makes exactly one record. A level held high for many cycles makes only one record.
- R9: After reset the queue is empty and `ovf_flag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the counter, the queue and all channels |
| rst_n | input | 1 | Synchronous reset, active low |
| pps_in | input | NUM_CH | Asynchronous pulse or frequency inputs, one bit per channel |
| rd_en | input | 1 | Removes the record shown on rd_data |
| clr_ovf | input | 1 | Clears the sticky overflow flag |
| rd_data | output | 36 | {valid, channel[2:0], stamp[31:0]} |
| ovf_flag | output | 1 | Sticky flag: at least one record was dropped |

## Verification
The assertions check on every cycle that:
- the counter goes up by one each cycle;
- a capture loads the count from that cycle;
- the edge detector never fires two cycles in a row;
- the arbiter grants at most one channel, and always the lowest pending one;
- a full queue does not grow, and an empty queue does not change when read;
- the overflow flag stays set until it is cleared.

Only the bench scenarios can show the following:
- the exact stamp values;
- that the divide-by-N thinning happens at the right edges;
- the order of records when all fifteen channel combinations fire together;
- which records survive a flood that overflows the queue.

// File: rtl/pps_pkg.sv
// Shared widths and the queue record layout for the pulse timestamper.
package pps_pkg;
    localparam int CH_W  = 3;
    localparam int CNT_W = 32;
    localparam int REC_W = 1 + CH_W + CNT_W;

    typedef struct packed {
        logic [CH_W-1:0]  ch;
        logic [CNT_W-1:0] stamp;
    } pps_rec_t;
endpackage

// File: rtl/pps_edge_sync.sv
// Two-flop synchronizer followed by a rising-edge detector.
// Assumes: pin is asynchronous to clk; each high/low level lasts at least
// one clock so that the edge can be seen.
module pps_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic edge_o
);
    logic meta_q, sync_q, prev_q;

    // Bring the pin into the clock domain and keep the previous level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= pin;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // A single-cycle strobe when the synchronized level goes from low to high.
    assign edge_o = sync_q & ~prev_q;

    // R8
    single_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o);
endmodule

// File: rtl/pps_divider.sv
// Counts detected edges and lets through every DIV_N-th one.
// Assumes: DIV_N >= 2 and edge_i is a single-cycle strobe.
module pps_divider #(
    parameter int DIV_N = 10_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_i,
    output logic pulse_o
);
    localparam int DW = $clog2(DIV_N);
    localparam logic [DW-1:0] LAST = DW'(DIV_N - 1);

    logic [DW-1:0] div_q;

    // Count edges modulo DIV_N.
    always_ff @(posedge clk) begin
        if (!rst_n)
            div_q <= '0;
        else if (edge_i)
            div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
    end

    // Let the edge through when it completes the count.
    assign pulse_o = edge_i && (div_q == LAST);

    // R5
    div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_q <= LAST);
endmodule

// File: rtl/pps_rec_fifo.sv
// Synchronous first-in first-out queue of channel-tagged records.
// Assumes: DEPTH is a power of two. A push while full is ignored, and a pop
// while empty is ignored.
module pps_rec_fifo
    import pps_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     push,
    input  pps_rec_t push_rec,
    input  logic     pop,
    output pps_rec_t head,
    output logic     empty,
    output logic     full
);
    localparam int AW = $clog2(DEPTH);

    pps_rec_t        mem [DEPTH];
    logic [AW-1:0]   wr_ptr, rd_ptr;
    logic [AW:0]     fill;
    logic            do_push, do_pop;

    assign empty   = (fill == '0);
    assign full    = (fill == (AW+1)'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    // Store an accepted record at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push)
            mem[wr_ptr] <= push_rec;
    end

    // Move the pointers and the fill level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            fill <= fill + (AW+1)'(do_push) - (AW+1)'(do_pop);
        end
    end

    // R6
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= (AW+1)'(DEPTH));
    // R6
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> $stable(fill) && $stable(wr_ptr));
    // R7
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty && $stable(rd_ptr));
endmodule

// File: rtl/pps_stamper.sv
// Multi-channel pulse timestamper. It has one shared free-running counter.
// Each channel has a synchronizer, an edge detector and an optional divider.
// Each channel keeps its stamp in a holding register. A lowest-first arbiter
// moves the held stamps into a single tagged queue, which is read through
// one word.
// Assumes: NUM_CH <= 8 (3-bit channel field). Channel 0 is the undivided
// reference.
module pps_stamper
    import pps_pkg::*;
#(
    parameter int         NUM_CH     = 4,
    parameter int         DIV_N      = 10_000_000,
    parameter logic [7:0] DIV_MASK   = 8'b0000_1110,
    parameter int         FIFO_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] pps_in,
    input  logic              rd_en,
    input  logic              clr_ovf,
    output logic [REC_W-1:0]  rd_data,
    output logic              ovf_flag
);
    logic [CNT_W-1:0]  cnt_q;
    logic [NUM_CH-1:0] ev, pend, grant, lost;
    logic [CNT_W-1:0]  hold [NUM_CH];
    pps_rec_t          win_rec, head;
    logic              any_grant, q_empty, q_full;

    // Shared time base: free-running, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    // Per-channel front end: synchronizer and edge detector, plus a divider
    // when the channel is selected in DIV_MASK.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic edge_w;
        pps_edge_sync i_sync (.clk(clk), .rst_n(rst_n), .pin(pps_in[i]), .edge_o(edge_w));
        if (DIV_MASK[i] && i != 0) begin : g_div
            pps_divider #(.DIV_N(DIV_N)) i_div (
                .clk(clk), .rst_n(rst_n), .edge_i(edge_w), .pulse_o(ev[i]));
        end else begin : g_pass
            assign ev[i] = edge_w;
        end
    end

    // Lowest pending channel wins the single queue slot this cycle.
    always_comb begin
        grant = '0;
        for (int i = 0; i < NUM_CH; i++)
            if (pend[i] && grant == '0) grant[i] = 1'b1;
    end

    // Build the record of the winning channel.
    always_comb begin
        win_rec = '0;
        for (int i = 0; i < NUM_CH; i++)
            if (grant[i]) begin
                win_rec.ch    = CH_W'(i);
                win_rec.stamp = hold[i];
            end
    end

    assign any_grant = |grant;
    assign lost      = ev & pend & ~grant;

    // Holding registers: capture on an event, release when granted.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_CH; i++) begin
            if (!rst_n) begin
                pend[i] <= 1'b0;
                hold[i] <= '0;
            end else if (ev[i] && (!pend[i] || grant[i])) begin
                pend[i] <= 1'b1;
                hold[i] <= cnt_q;
            end else if (grant[i]) begin
                pend[i] <= 1'b0;
            end
        end
    end

    pps_rec_fifo #(.DEPTH(FIFO_DEPTH)) i_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(any_grant), .push_rec(win_rec),
        .pop(rd_en), .head(head),
        .empty(q_empty), .full(q_full)
    );

    // Sticky overflow: set by a drop at a full queue or a lost capture.
    always_ff @(posedge clk) begin
        if (!rst_n) ovf_flag <= 1'b0;
        else        ovf_flag <= (ovf_flag & ~clr_ovf) | (any_grant & q_full) | (|lost);
    end

    // The read word is all zeros while the queue is empty.
    assign rd_data = q_empty ? '0 : {1'b1, head};

    // R1
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cnt_q == $past(cnt_q) + 1'b1);
    // R4
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    // R6
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !clr_ovf) |=> ovf_flag);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        // R1
        capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ev[g] && !pend[g]) |=> pend[g] && hold[g] == $past(cnt_q));
        if (g > 0) begin : g_lo
            // R4
            lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
                grant[g] |-> pend[g-1:0] == '0);
        end
    end
endmodule

// File: tb/test_pps_stamper.sv
module test_pps_stamper;
    localparam int NCH = 4;
    localparam int DN  = 3;
    localparam int DEP = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NCH-1:0]  pins = '0;
    logic            rd_en = 1'b0;
    logic            clr_ovf = 1'b0;
    logic [35:0]     rd_data;
    logic            ovf_flag;

    int unsigned tcnt = 0;
    int n_chk = 0, n_bad = 0;
    int ecnt [NCH];

    always #10 clk = ~clk;

    // Bench copy of the time base: clock edges since reset release.
    always @(posedge clk) if (rst_n) tcnt <= tcnt + 1;

    pps_stamper #(.NUM_CH(NCH), .DIV_N(DN), .DIV_MASK(8'b0000_1100), .FIFO_DEPTH(DEP))
    i_pps_stamper (.clk(clk), .rst_n(rst_n), .pps_in(pins), .rd_en(rd_en),
                   .clr_ovf(clr_ovf), .rd_data(rd_data), .ovf_flag(ovf_flag));

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FIFO check FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive channels s high for `hold` cycles, then settle; returns drive time.
    task automatic fire(input logic [NCH-1:0] s, input int hold, output int unsigned m0);
        @(negedge clk);
        m0 = tcnt;
        pins = s;
        repeat (hold) @(negedge clk);
        pins = '0;
        repeat (12) @(negedge clk);
    endtask

    // Sample the shown record, then pop it.
    task automatic read_rec(output logic [35:0] w);
        w = rd_data;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("Watchdog FAIL R3: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int unsigned m0;
        logic [35:0] w;
        int unsigned stamps [$];
        for (int c = 0; c < NCH; c++) ecnt[c] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state, R7 empty word
        check(rd_data == '0, "R9/R7 empty after reset", rd_data, 0);
        check(ovf_flag == 1'b0, "R9 ovf after reset", ovf_flag, 0);

        // R1 R2 R4 R5: all 15 simultaneous channel combinations
        for (int s = 1; s < 16; s++) begin
            fire(NCH'(s), 3, m0);
            for (int c = 0; c < NCH; c++) begin
                if (s[c]) begin
                    ecnt[c]++;
                    if (c < 2 || ecnt[c] % DN == 0) begin
                        read_rec(w);
                        check(w[35] == 1'b1, "R2 valid", w[35], 1);
                        check(w[34:32] == 3'(c), "R4 channel order", w[34:32], c);
                        check(w[31:0] == m0 + 2, "R1 stamp", w[31:0], m0 + 2);
                    end
                end
            end
            check(rd_data == '0, "R5 no extra record", rd_data, 0);
        end

        // R8: held level gives a single record
        fire(4'b0010, 40, m0);
        read_rec(w);
        check(w == {1'b1, 3'd1, 32'(m0 + 2)}, "R8 held level record", w, {1'b1, 3'd1, 32'(m0 + 2)});
        check(rd_data == '0, "R8 only one record", rd_data, 0);

        // R6: overflow by ten records into a queue of eight
        stamps.delete();
        for (int k = 0; k < DEP + 2; k++) begin
            fire(4'b0001, 3, m0);
            stamps.push_back(m0 + 2);
            if (k == DEP - 1) check(ovf_flag == 1'b0, "R6 no ovf when just full", ovf_flag, 0);
        end
        check(ovf_flag == 1'b1, "R6 ovf set", ovf_flag, 1);
        // R3 order and R6 survivors
        for (int k = 0; k < DEP; k++) begin
            read_rec(w);
            check(w == {1'b1, 3'd0, 32'(stamps[k])}, "R3 in-order survivor", w, {1'b1, 3'd0, 32'(stamps[k])});
        end
        // R7: pops on empty have no effect
        read_rec(w);
        check(w == '0, "R7 empty read", w, 0);
        read_rec(w);
        check(rd_data == '0, "R7 still empty", rd_data, 0);
        check(ovf_flag == 1'b1, "R6 ovf sticky", ovf_flag, 1);
        clr_ovf = 1'b1;
        @(negedge clk);
        clr_ovf = 1'b0;
        @(negedge clk);
        check(ovf_flag == 1'b0, "R6 ovf cleared", ovf_flag, 0);

        // R3: a record after the queue wraps
        fire(4'b0001, 2, m0);
        read_rec(w);
        check(w == {1'b1, 3'd0, 32'(m0 + 2)}, "R3 after wrap", w, {1'b1, 3'd0, 32'(m0 + 2)});

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule